// File: doc/BRIEF.md
# Nibble Memory Call Stack Controller

This block handles subroutine calls and returns for a small 4-bit processor whose data memory holds one nibble per address. On a call it saves the current 12-bit program counter into data memory as three nibbles. It then loads a new program counter built from the three target nibbles that the instruction stream supplied. On a return it writes a 4-bit literal into register R0, reads the saved nibbles back and reloads the program counter.

The frame for stack level `p` starts at address `0x10 + 3*p`, and the least significant nibble is stored first. The pointer is 3 bits wide and allows five nested levels. Either misuse, a sixth nested call or a return from an empty stack, stops execution. The faulting pointer value stays visible until a key press clears the fault. That key press is consumed only for clearing the fault.

The decoder around the block raises `call_i` in the cycle where software writes the low target nibble. At that point the middle and high target nibbles are already on their inputs. The decoder raises `ret_i` together with the literal. The memory port is a simple single-cycle write and asynchronous-read interface.

Top module: `nstk_ctrl`

## Requirements
- R1: After reset the pointer output is 0, and `err_o`, `halt_o`, `busy_o`, `mem_we_o`, `mem_re_o`, `pc_load_o` and `r0_we_o` are all low.
- R2: An accepted call writes the sampled `pc_i` to memory in the three cycles right after the strobe. Nibble k (bits 4k+3..4k) goes to address `0x10 + 3*SP + k`, with k = 0, 1, 2 in that order and `mem_we_o` high in each of those cycles.
- R3: In the fourth cycle after an accepted call, `pc_load_o` pulses for one cycle with `pc_new_o = {tgt_hi_i, tgt_mid_i, tgt_lo_i}` as sampled with the strobe. The pointer is one higher from that cycle on. `busy_o` is high from the first cycle after the strobe through the load cycle and low afterwards.
- R4: An accepted return decrements the pointer to P. It then reads addresses `0x10 + 3*P + k`, k = 0, 1, 2, over three consecutive cycles with `mem_re_o` high. In the first of those cycles it pulses `r0_we_o` with `r0_data_o` equal to the literal. In the fourth cycle it pulses `pc_load_o` with the three read nibbles, the first one read as bits 3..0.
- R5: A call while the pointer is 5 performs no memory write and no PC load. From the next cycle, `err_o` and `halt_o` are high and `sp_o` shows 6 (binary 110).
- R6: A return while the pointer is 0 performs no read and no R0 write. From the next cycle, `err_o` and `halt_o` are high and `sp_o` shows 7 (binary 111).
- R7: While the error is set, call and return strobes cause no memory access, no PC load and no pointer change.
- R8: A key press during an error clears it in the next cycle, and `sp_o` then shows the pointer value from before the faulting strobe. Apart from that the key has no effect. A key press with no error pending changes nothing.
- R9: Call and return strobes that arrive while `busy_o` is high are ignored.
- R10: When a call and a return strobe arrive in the same idle cycle, only the call is performed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Call strobe (write to the low target nibble) |
| tgt_lo_i | input | 4 | Low target nibble written with the strobe |
| tgt_mid_i | input | 4 | Middle target nibble |
| tgt_hi_i | input | 4 | High target nibble |
| ret_i | input | 1 | Return strobe |
| ret_lit_i | input | 4 | Literal loaded into R0 on return |
| pc_i | input | 12 | Current program counter to save |
| key_i | input | 1 | Key-press event, clears a pending error |
| mem_we_o | output | 1 | Data memory write request |
| mem_re_o | output | 1 | Data memory read request |
| mem_addr_o | output | 8 | Data memory nibble address |
| mem_wdata_o | output | 4 | Nibble to write |
| mem_rdata_i | input | 4 | Nibble read, valid in the same cycle as the address |
| pc_load_o | output | 1 | New program counter is valid |
| pc_new_o | output | 12 | New program counter |
| r0_we_o | output | 1 | R0 write strobe |
| r0_data_o | output | 4 | Value for R0 |
| sp_o | output | 3 | Stack pointer, or the faulting value while in error |
| halt_o | output | 1 | Execution halted |
| err_o | output | 1 | Stack error pending |
| busy_o | output | 1 | Transfer sequence in progress |

## Verification
A wrong pointer shows up within three cycles of the next call or return as a wrong memory address, because every transfer address is derived from it. A wrong nibble index shows as a misordered address or nibble in the same transfer. A dropped or misplaced nibble appears at the `pc_new_o` of the matching return, possibly many operations later. The nested call/return sequence therefore compares every restored program counter against the one saved at that depth. A stuck error or busy state shows in the very next cycle as a strobe that is ignored or acted upon against the rules. The directed tests check for this with strobes during a fault, during a transfer and in the same cycle.

// File: rtl/nstk_pkg.sv
package nstk_pkg;
    localparam int unsigned NIB_W = 4;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_POP  = 2'd2,
        ST_LOAD = 2'd3
    } stk_state_e;
endpackage

// File: rtl/nstk_addr_gen.sv
module nstk_addr_gen #(
    parameter int unsigned SP_W  = 3,
    parameter int unsigned IDX_W = 2,
    parameter int unsigned AW    = 8,
    parameter logic [AW-1:0] BASE = 8'h10
) (
    input  logic [SP_W-1:0]  sp,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr
);
    logic [AW-1:0] sp_ext;
    logic [AW-1:0] frame_off;

    always_comb begin
        sp_ext    = AW'(sp);
        frame_off = (sp_ext << 1) + sp_ext;
        addr      = BASE + frame_off + AW'(idx);
    end
endmodule

// File: rtl/nstk_bounds.sv
module nstk_bounds #(
    parameter int unsigned SP_W      = 3,
    parameter int unsigned MAX_DEPTH = 5
) (
    input  logic [SP_W-1:0] sp,
    output logic            full,
    output logic            empty,
    output logic [SP_W-1:0] ovf_code,
    output logic [SP_W-1:0] unf_code
);
    always_comb begin
        full     = (sp == SP_W'(MAX_DEPTH));
        empty    = (sp == '0);
        ovf_code = SP_W'(MAX_DEPTH + 1);
        unf_code = '1;
    end
endmodule

// File: rtl/nstk_nib_sel.sv
module nstk_nib_sel #(
    parameter int unsigned W     = 12,
    parameter int unsigned NIB_W = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [W-1:0]     word,
    input  logic [IDX_W-1:0] idx,
    output logic [NIB_W-1:0] nib
);
    localparam int unsigned NNIB = W / NIB_W;

    logic [NIB_W-1:0] lanes [NNIB];

    for (genvar g = 0; g < NNIB; g++) begin : g_lane
        assign lanes[g] = word[g*NIB_W +: NIB_W];
    end

    always_comb begin
        nib = '0;
        for (int k = 0; k < NNIB; k++) begin
            if (idx == IDX_W'(k)) nib = lanes[k];
        end
    end
endmodule

// File: rtl/nstk_ctrl.sv
module nstk_ctrl
    import nstk_pkg::*;
#(
    parameter int unsigned PC_W      = 12,
    parameter int unsigned SP_W      = 3,
    parameter int unsigned AW        = 8,
    parameter int unsigned MAX_DEPTH = 5,
    parameter logic [AW-1:0] BASE    = 8'h10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     call_i,
    input  logic [NIB_W-1:0]         tgt_lo_i,
    input  logic [NIB_W-1:0]         tgt_mid_i,
    input  logic [PC_W-2*NIB_W-1:0]  tgt_hi_i,
    input  logic                     ret_i,
    input  logic [NIB_W-1:0]         ret_lit_i,
    input  logic [PC_W-1:0]          pc_i,
    input  logic                     key_i,
    output logic                     mem_we_o,
    output logic                     mem_re_o,
    output logic [AW-1:0]            mem_addr_o,
    output logic [NIB_W-1:0]         mem_wdata_o,
    input  logic [NIB_W-1:0]         mem_rdata_i,
    output logic                     pc_load_o,
    output logic [PC_W-1:0]          pc_new_o,
    output logic                     r0_we_o,
    output logic [NIB_W-1:0]         r0_data_o,
    output logic [SP_W-1:0]          sp_o,
    output logic                     halt_o,
    output logic                     err_o,
    output logic                     busy_o
);
    localparam int unsigned NNIB  = PC_W / NIB_W;
    localparam int unsigned IDX_W = (NNIB > 1) ? $clog2(NNIB) : 1;

    typedef struct packed {
        stk_state_e        st;
        logic [IDX_W-1:0]  idx;
        logic [SP_W-1:0]   sp;
        logic              err;
        logic [SP_W-1:0]   err_sp;
        logic [PC_W-1:0]   frame;
        logic [PC_W-1:0]   dest;
        logic [NIB_W-1:0]  lit;
    } regs_t;

    regs_t q, d;

    logic            at_full, at_empty;
    logic [SP_W-1:0] ovf_code, unf_code;
    logic            last_nib;
    logic [PC_W-1:0] popped;

    nstk_bounds #(
        .SP_W      (SP_W),
        .MAX_DEPTH (MAX_DEPTH)
    ) u_bounds (
        .sp       (q.sp),
        .full     (at_full),
        .empty    (at_empty),
        .ovf_code (ovf_code),
        .unf_code (unf_code)
    );

    nstk_addr_gen #(
        .SP_W  (SP_W),
        .IDX_W (IDX_W),
        .AW    (AW),
        .BASE  (BASE)
    ) u_addr (
        .sp   (q.sp),
        .idx  (q.idx),
        .addr (mem_addr_o)
    );

    nstk_nib_sel #(
        .W     (PC_W),
        .NIB_W (NIB_W),
        .IDX_W (IDX_W)
    ) u_wsel (
        .word (q.frame),
        .idx  (q.idx),
        .nib  (mem_wdata_o)
    );

    // Merge the nibble arriving from memory into the frame being rebuilt.
    always_comb begin
        popped = q.frame;
        for (int k = 0; k < NNIB; k++) begin
            if (q.idx == IDX_W'(k)) popped[k*NIB_W +: NIB_W] = mem_rdata_i;
        end
    end

    assign last_nib = (q.idx == IDX_W'(NNIB - 1));

    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (q.err) begin
                    // Strobes are dropped; the key only clears the fault.
                    if (key_i) d.err = 1'b0;
                end else if (call_i) begin
                    if (at_full) begin
                        d.err    = 1'b1;
                        d.err_sp = ovf_code;
                    end else begin
                        d.st    = ST_PUSH;
                        d.idx   = '0;
                        d.frame = pc_i;
                        d.dest  = {tgt_hi_i, tgt_mid_i, tgt_lo_i};
                    end
                end else if (ret_i) begin
                    if (at_empty) begin
                        d.err    = 1'b1;
                        d.err_sp = unf_code;
                    end else begin
                        d.st  = ST_POP;
                        d.idx = '0;
                        d.sp  = q.sp - 1'b1;
                        d.lit = ret_lit_i;
                    end
                end
            end
            ST_PUSH: begin
                if (last_nib) begin
                    d.st = ST_LOAD;
                    d.sp = q.sp + 1'b1;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_POP: begin
                d.frame = popped;
                if (last_nib) begin
                    d.st   = ST_LOAD;
                    d.dest = popped;
                end else begin
                    d.idx = q.idx + 1'b1;
                end
            end
            ST_LOAD: begin
                d.st  = ST_IDLE;
                d.idx = '0;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_we_o  = (q.st == ST_PUSH);
    assign mem_re_o  = (q.st == ST_POP);
    assign pc_load_o = (q.st == ST_LOAD);
    assign pc_new_o  = q.dest;
    assign r0_we_o   = (q.st == ST_POP) && (q.idx == '0);
    assign r0_data_o = q.lit;
    assign sp_o      = q.err ? q.err_sp : q.sp;
    assign halt_o    = q.err;
    assign err_o     = q.err;
    assign busy_o    = (q.st != ST_IDLE);
endmodule

// File: rtl/nstk_ctrl_chk.sv
module nstk_ctrl_chk #(
    parameter int unsigned PC_W      = 12,
    parameter int unsigned SP_W      = 3,
    parameter int unsigned AW        = 8,
    parameter int unsigned MAX_DEPTH = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             call_i,
    input logic             ret_i,
    input logic             key_i,
    input logic             mem_we_o,
    input logic             mem_re_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic             pc_load_o,
    input logic             r0_we_o,
    input logic [SP_W-1:0]  sp_o,
    input logic             err_o,
    input logic             halt_o,
    input logic             busy_o
);
    // R2
    no_dual_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    // R3
    load_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> busy_o);

    // R3
    load_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |=> !busy_o);

    // R4
    r0_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r0_we_o |-> mem_re_o);

    // R5
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> (sp_o > SP_W'(MAX_DEPTH)));

    // R6
    halt_follows_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halt_o == err_o);

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !key_i) |=> (err_o && $stable(sp_o) && !busy_o));

    // R8
    key_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && key_i) |=> !err_o);

    // R9
    busy_no_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !err_o);
endmodule

bind nstk_ctrl nstk_ctrl_chk #(
    .PC_W      (PC_W),
    .SP_W      (SP_W),
    .AW        (AW),
    .MAX_DEPTH (MAX_DEPTH)
) u_chk (.*);

// File: tb/nstk_ctrl_test.sv
`timescale 1ns/1ps
module nstk_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, ret_i = 1'b0, key_i = 1'b0;
    logic [3:0]  tgt_lo_i = '0, tgt_mid_i = '0, tgt_hi_i = '0, ret_lit_i = '0;
    logic [11:0] pc_i = '0;
    logic        mem_we_o, mem_re_o, pc_load_o, r0_we_o, halt_o, err_o, busy_o;
    logic [7:0]  mem_addr_o;
    logic [3:0]  mem_wdata_o, mem_rdata_i, r0_data_o;
    logic [11:0] pc_new_o;
    logic [2:0]  sp_o;

    logic [3:0]  dmem [256];
    logic        fill = 1'b1;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    nstk_ctrl uut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .tgt_lo_i(tgt_lo_i),
        .tgt_mid_i(tgt_mid_i), .tgt_hi_i(tgt_hi_i), .ret_i(ret_i),
        .ret_lit_i(ret_lit_i), .pc_i(pc_i), .key_i(key_i),
        .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
        .pc_load_o(pc_load_o), .pc_new_o(pc_new_o), .r0_we_o(r0_we_o),
        .r0_data_o(r0_data_o), .sp_o(sp_o), .halt_o(halt_o), .err_o(err_o),
        .busy_o(busy_o)
    );

    // Data memory model: one nibble per address, asynchronous read.
    always @(posedge clk) begin
        if (fill) begin
            for (int i = 0; i < 256; i++) dmem[i] <= 4'hE;
        end else if (mem_we_o) begin
            dmem[mem_addr_o] <= mem_wdata_o;
        end
    end
    assign mem_rdata_i = dmem[mem_addr_o];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    task automatic pulse(input logic c, input logic r, input logic k,
                         input logic [11:0] pc, input logic [11:0] arg);
        @(negedge clk);
        call_i = c; ret_i = r; key_i = k; pc_i = pc;
        tgt_hi_i = arg[11:8]; tgt_mid_i = arg[7:4]; tgt_lo_i = arg[3:0];
        ret_lit_i = arg[3:0];
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0; key_i = 1'b0;
    endtask

    // op 0 = call (arg = target), op 1 = return (arg[3:0] = literal)
    task automatic run_op(input logic op, input logic [11:0] pc, input logic [11:0] arg,
                          input logic [11:0] exp_pc, input logic [2:0] exp_sp);
        logic [2:0] base;
        logic [7:0] a0;
        base = op ? sp_o - 3'd1 : sp_o;
        a0   = 8'h10 + 8'(base) * 8'd3;
        pulse(!op, op, 1'b0, pc, arg);
        for (int c = 1; c <= 3; c++) begin
            check("R3 busy during transfer", 32'(busy_o), 32'd1);
            check("R2/R4 transfer address", 32'(mem_addr_o), 32'(a0 + 8'(c - 1)));
            if (!op) begin
                check("R2 write strobe", 32'(mem_we_o), 32'd1);
                check("R2 nibble order", 32'(mem_wdata_o), 32'(pc[(c-1)*4 +: 4]));
            end else begin
                check("R4 read strobe", 32'(mem_re_o), 32'd1);
                check("R4 R0 write timing", 32'(r0_we_o), 32'(c == 1));
                if (c == 1) check("R4 R0 literal", 32'(r0_data_o), 32'(arg[3:0]));
            end
            @(negedge clk);
        end
        check("R3/R4 load pulse", 32'(pc_load_o), 32'd1);
        check("R3/R4 new PC", 32'(pc_new_o), 32'(exp_pc));
        check("R3/R4 pointer", 32'(sp_o), 32'(exp_sp));
        @(negedge clk);
        check("R3 busy released", 32'(busy_o), 32'd0);
        check("R3 load single pulse", 32'(pc_load_o), 32'd0);
        if (!op) begin
            for (int k = 0; k < 3; k++)
                check("R2 stored nibble", 32'(dmem[a0 + 8'(k)]), 32'(pc[k*4 +: 4]));
        end
    endtask

    // {op, pc, arg, exp_pc, exp_sp}
    localparam logic [39:0] VEC [10] = '{
        {1'b0, 12'h123, 12'h4A5, 12'h4A5, 3'd1},
        {1'b0, 12'h4A6, 12'h7F0, 12'h7F0, 3'd2},
        {1'b0, 12'h7F1, 12'h808, 12'h808, 3'd3},
        {1'b0, 12'h809, 12'hC3E, 12'hC3E, 3'd4},
        {1'b0, 12'hC3F, 12'hFFF, 12'hFFF, 3'd5},
        {1'b1, 12'h000, 12'h009, 12'hC3F, 3'd4},
        {1'b1, 12'h000, 12'h000, 12'h809, 3'd3},
        {1'b1, 12'h000, 12'h00F, 12'h7F1, 3'd2},
        {1'b1, 12'h000, 12'h005, 12'h4A6, 3'd1},
        {1'b1, 12'h000, 12'h00A, 12'h123, 3'd0}
    };

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        fill = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 pointer", 32'(sp_o), 32'd0);
        check("R1 error", 32'(err_o), 32'd0);
        check("R1 halt", 32'(halt_o), 32'd0);
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 requests", 32'({mem_we_o, mem_re_o, pc_load_o, r0_we_o}), 32'd0);

        foreach (VEC[i])
            run_op(VEC[i][39], VEC[i][38:27], VEC[i][26:15], VEC[i][14:3], VEC[i][2:0]);

        // R8 key with no error pending
        pulse(1'b0, 1'b0, 1'b1, 12'h0, 12'h0);
        check("R8 idle key pointer", 32'(sp_o), 32'd0);
        check("R8 idle key activity", 32'({err_o, busy_o, pc_load_o}), 32'd0);

        // R6 underflow
        pulse(1'b0, 1'b1, 1'b0, 12'h0, 12'h003);
        check("R6 error", 32'(err_o), 32'd1);
        check("R6 halt", 32'(halt_o), 32'd1);
        check("R6 shown pointer", 32'(sp_o), 32'd7);
        check("R6 no access", 32'({mem_re_o, r0_we_o, busy_o}), 32'd0);

        // R7 strobes during error
        pulse(1'b1, 1'b0, 1'b0, 12'h321, 12'h654);
        for (int c = 0; c < 4; c++) begin
            check("R7 call ignored", 32'({mem_we_o, mem_re_o, pc_load_o, busy_o}), 32'd0);
            check("R7 pointer held", 32'(sp_o), 32'd7);
            @(negedge clk);
        end
        pulse(1'b0, 1'b1, 1'b0, 12'h0, 12'h004);
        check("R7 return ignored", 32'({mem_re_o, r0_we_o, busy_o}), 32'd0);
        check("R7 pointer held", 32'(sp_o), 32'd7);

        // R8 key clears
        pulse(1'b0, 1'b0, 1'b1, 12'h0, 12'h0);
        check("R8 cleared", 32'({err_o, halt_o}), 32'd0);
        check("R8 pointer restored", 32'(sp_o), 32'd0);
        check("R8 key discarded", 32'({busy_o, mem_we_o, mem_re_o}), 32'd0);

        // R9 return strobe while busy
        @(negedge clk);
        call_i = 1'b1; pc_i = 12'h055;
        {tgt_hi_i, tgt_mid_i, tgt_lo_i} = 12'h3C3;
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b1; ret_lit_i = 4'h6;
        @(negedge clk);
        ret_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R9 load", 32'(pc_load_o), 32'd1);
        check("R9 new PC", 32'(pc_new_o), 32'h3C3);
        @(negedge clk);
        check("R9 pointer", 32'(sp_o), 32'd1);
        @(negedge clk);
        check("R9 no pop", 32'({mem_re_o, r0_we_o, busy_o}), 32'd0);
        check("R9 pointer held", 32'(sp_o), 32'd1);

        // R10 simultaneous strobes
        @(negedge clk);
        call_i = 1'b1; ret_i = 1'b1; pc_i = 12'h9AB; ret_lit_i = 4'h1;
        {tgt_hi_i, tgt_mid_i, tgt_lo_i} = 12'h111;
        @(negedge clk);
        call_i = 1'b0; ret_i = 1'b0;
        check("R10 call taken", 32'({mem_we_o, mem_re_o, r0_we_o}), 32'b100);
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        check("R10 new PC", 32'(pc_new_o), 32'h111);
        check("R10 pointer", 32'(sp_o), 32'd2);
        @(negedge clk);
        run_op(1'b1, 12'h0, 12'h002, 12'h9AB, 3'd1);
        run_op(1'b1, 12'h0, 12'h003, 12'h055, 3'd0);

        // R5 overflow
        for (int k = 0; k < 5; k++)
            run_op(1'b0, 12'h200 + 12'(k), 12'h300 + 12'(k), 12'h300 + 12'(k), 3'(k + 1));
        pulse(1'b1, 1'b0, 1'b0, 12'h5A5, 12'h777);
        check("R5 error", 32'({err_o, halt_o}), 32'b11);
        check("R5 shown pointer", 32'(sp_o), 32'd6);
        check("R5 no write", 32'({mem_we_o, busy_o}), 32'd0);
        repeat (4) @(negedge clk);
        check("R5 no PC load", 32'(pc_load_o), 32'd0);
        for (int k = 0; k < 3; k++)
            check("R5 memory untouched", 32'(dmem[8'h1F + 8'(k)]), 32'hE);
        pulse(1'b0, 1'b0, 1'b1, 12'h0, 12'h0);
        check("R8 pointer after overflow", 32'(sp_o), 32'd5);
        check("R8 cleared after overflow", 32'(err_o), 32'd0);
        run_op(1'b1, 12'h0, 12'h00C, 12'h204, 3'd4);

        summary();
        $finish;
    end
endmodule